// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block turns four supply-rail comparator flags into an active-low system reset. Each flag is already synchronized and reads 1 while its rail is above its undervoltage level. A per-rail glitch filter passes only long dips. A down-counter stretches reset release by a programmed number of cycles after the sequencer reports that power-up is complete and every rail is good.

A small state machine drives the reset. Its states are HOLD (reset asserted, waiting), DELAY (release counter running), RUN (reset released) and FAULT (latched failure). Its transitions are:
- start: HOLD to DELAY, when sequencing is complete, every filtered rail is good and no shutdown is requested.
- abort: DELAY to HOLD, on a shutdown or a failed rail.
- release: DELAY to RUN, when the counter has expired.
- drop: RUN to HOLD, on a shutdown, or on a failed rail while escalation is off.
- escalate: RUN to FAULT, on a failed rail while escalation is on.
- clear: FAULT to HOLD, on a fault clear.

In FAULT the block raises a fault flag, requests that all supply enables be dropped, and keeps the index of the failing rail. A margining override holds the reset output high in every state.

Top module: `rail_reset_ctrl`

## Requirements
- R1: During and right after reset (`rst_n` low), `rst_out_n` is 0 (with `rst_dis` low), `fault_out` and `en_drop_req` are 0, and `fault_chan` is 0.
- R2: `rst_out_n` stays low until `seq_done` is 1 and every filtered rail is good. Inputs change between clock edges. If those inputs become true before edge E0, `rst_out_n` first reads high after edge E0+`delay_cfg`+1.
- R3: `delay_cfg` is sampled only on the start transition. Changing it while the counter runs has no effect on the release time.
- R4: A rail flag that is low for fewer than FILT_SAMPLES consecutive clock samples has no effect on `rst_out_n` or `fault_out`.
- R5: A rail flag that is low for FILT_SAMPLES consecutive samples, starting at edge 1, drives `rst_out_n` low after edge FILT_SAMPLES+1.
- R6: While any filtered rail is failed, the release delay does not start. The delay restarts in full one cycle after the last rail's filter clears: its flag is high at edge L+1, the count is reloaded at edge L+2, and release follows after edge L+3+`delay_cfg`.
- R7: With `fault_on_uv`=1, a qualified dip while released moves the block to FAULT. After the same edge as in R5, `fault_out`=1, `en_drop_req`=1 and `rst_out_n`=0. All three hold until `fault_clr`.
- R8: On escalation, `fault_chan` records, in binary, the lowest-numbered rail (0 to 3) whose filter has failed. It stays unchanged through later dips until `fault_clr`, which clears it to 0 and returns the block to HOLD.
- R9: While `rst_dis` is 1, `rst_out_n` is 1 in every state, within the same cycle.
- R10: `shutdown`=1 drives `rst_out_n` low after the next clock edge and keeps it low while asserted, whatever the rail flags.
- R11: With `fault_on_uv`=0, a qualified dip never raises `fault_out`. After recovery the reset releases again without `fault_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rail_ok | input | NUM_RAILS | Synchronized comparator flags, 1 = rail above its undervoltage level |
| seq_done | input | 1 | Power-up sequencing complete |
| shutdown | input | 1 | Power-down command, forces reset low |
| rst_dis | input | 1 | Margining override, forces `rst_out_n` high |
| fault_on_uv | input | 1 | Escalate an undervoltage reset to a latched fault |
| delay_cfg | input | DLY_W | Release delay in cycles, sampled on start |
| fault_clr | input | 1 | Clears a latched fault |
| rst_out_n | output | 1 | Active-low system reset |
| fault_out | output | 1 | Latched fault flag |
| en_drop_req | output | 1 | Request to pull every supply enable low |
| fault_chan | output | $clog2(NUM_RAILS) | Index of the rail that caused the fault |

## Verification
The bench builds the block with FILT_SAMPLES=4, DLY_W=6 and NUM_RAILS=4. The short filter puts dip lengths on both sides of the qualification threshold within a few cycles. The narrow counter makes it cheap to sweep every release delay from 0 to 15. All fifteen non-empty combinations of failing rails are driven into the escalation path, and the bench computes the expected channel index as the lowest set bit.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    // Supervisor states
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DELAY = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } sup_state_e;

endpackage

// File: rtl/rrc_glitch_filter.sv
module rrc_glitch_filter #(
    parameter int SAMPLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_ok,
    output logic rail_fail
);

    localparam int CW = $clog2(SAMPLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SAMPLES);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples, saturate at the limit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cnt <= '0;
        else if (rail_ok)
            low_cnt <= '0;
        else if (low_cnt != LIMIT)
            low_cnt <= low_cnt + 1'b1;
    end

    assign rail_fail = (low_cnt == LIMIT);

    // R5
    fail_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_fail) |-> $past(!rail_ok));

    // R4
    good_clears_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rail_ok |=> !rail_fail);

endmodule

// File: rtl/rrc_delay_timer.sv
module rrc_delay_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         done
);

    logic [W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (run && remain != '0)
            remain <= remain - 1'b1;
    end

    assign done = (remain == '0);

    // R3
    count_moves_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && remain != '0) |=> (remain < $past(remain)));

endmodule

// File: rtl/rrc_fault_report.sv
module rrc_fault_report #(
    parameter int NUM = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic                   clear,
    input  logic [NUM-1:0]         fail_vec,
    output logic [$clog2(NUM)-1:0] chan
);

    localparam int IW = $clog2(NUM);

    logic [IW-1:0] lowest;

    // Lowest-numbered failing rail wins
    always_comb begin
        lowest = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (fail_vec[i])
                lowest = IW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chan <= '0;
        else if (clear)
            chan <= '0;
        else if (capture)
            chan <= lowest;
    end

    // R8
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(capture) && !$past(clear)) |-> $stable(chan));

endmodule

// File: rtl/rail_reset_ctrl.sv
module rail_reset_ctrl #(
    parameter int NUM_RAILS    = 4,
    parameter int FILT_SAMPLES = 16,
    parameter int DLY_W        = 20
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_RAILS-1:0]         rail_ok,
    input  logic                         seq_done,
    input  logic                         shutdown,
    input  logic                         rst_dis,
    input  logic                         fault_on_uv,
    input  logic [DLY_W-1:0]             delay_cfg,
    input  logic                         fault_clr,
    output logic                         rst_out_n,
    output logic                         fault_out,
    output logic                         en_drop_req,
    output logic [$clog2(NUM_RAILS)-1:0] fault_chan
);

    import rrc_pkg::*;

    sup_state_e           state, nxt;
    logic [NUM_RAILS-1:0] rail_fail;
    logic                 all_good;
    logic                 tmr_done;
    logic                 tmr_load;
    logic                 cap_fault;

    // One filter per rail
    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_filt
        rrc_glitch_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .rail_ok  (rail_ok[g]),
            .rail_fail(rail_fail[g])
        );
    end

    assign all_good = ~|rail_fail;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HOLD: begin
                if (!shutdown && seq_done && all_good)
                    nxt = ST_DELAY;                      // start
            end
            ST_DELAY: begin
                if (shutdown || !all_good)
                    nxt = ST_HOLD;                       // abort
                else if (tmr_done)
                    nxt = ST_RUN;                        // release
            end
            ST_RUN: begin
                if (shutdown)
                    nxt = ST_HOLD;                       // drop
                else if (!all_good)
                    nxt = fault_on_uv ? ST_FAULT : ST_HOLD; // escalate / drop
            end
            ST_FAULT: begin
                if (fault_clr)
                    nxt = ST_HOLD;                       // clear
            end
            default: nxt = ST_HOLD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HOLD;
        else
            state <= nxt;
    end

    assign tmr_load  = (state == ST_HOLD) && (nxt == ST_DELAY);
    assign cap_fault = (state == ST_RUN) && (nxt == ST_FAULT);

    rrc_delay_timer #(.W(DLY_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(delay_cfg),
        .run     (state == ST_DELAY),
        .done    (tmr_done)
    );

    rrc_fault_report #(.NUM(NUM_RAILS)) u_rep (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_fault),
        .clear   ((state == ST_FAULT) && fault_clr),
        .fail_vec(rail_fail),
        .chan    (fault_chan)
    );

    // Outputs
    always_comb begin
        rst_out_n   = rst_dis || (state == ST_RUN);
        fault_out   = (state == ST_FAULT);
        en_drop_req = (state == ST_FAULT);
    end

    // R2
    release_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(tmr_done));

    // R10
    shutdown_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && state != ST_FAULT) |=> (state == ST_HOLD));

    // R7
    escalate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !all_good && fault_on_uv && !shutdown) |=> fault_out);

    // R11
    no_fault_without_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_out && !fault_on_uv) |=> !fault_out);

endmodule

// File: tb/sim_rail_reset_ctrl.sv
module sim_rail_reset_ctrl;

    localparam int NR = 4;
    localparam int FS = 4;
    localparam int DW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_ok = '1;
    logic          seq_done = 1'b0;
    logic          shutdown = 1'b0;
    logic          rst_dis = 1'b0;
    logic          fault_on_uv = 1'b0;
    logic [DW-1:0] delay_cfg = '0;
    logic          fault_clr = 1'b0;
    logic          rst_out_n, fault_out, en_drop_req;
    logic [1:0]    fault_chan;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rail_reset_ctrl #(.NUM_RAILS(NR), .FILT_SAMPLES(FS), .DLY_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .rail_ok(rail_ok), .seq_done(seq_done),
        .shutdown(shutdown), .rst_dis(rst_dis), .fault_on_uv(fault_on_uv),
        .delay_cfg(delay_cfg), .fault_clr(fault_clr), .rst_out_n(rst_out_n),
        .fault_out(fault_out), .en_drop_req(en_drop_req), .fault_chan(fault_chan)
    );

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Return to HOLD with good rails and no sequencing flag
    task automatic go_hold();
        seq_done = 1'b0;
        shutdown = 1'b1;
        @(negedge clk);
        shutdown = 1'b0;
        rail_ok  = '1;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Start from HOLD, count negedges until reset releases
    task automatic bring_up(input int d, output int n);
        delay_cfg = DW'(d);
        seq_done  = 1'b1;
        n = 0;
        while (!rst_out_n && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Drive a dip, log first low and first re-release negedge
    task automatic dip(input int len, input logic [NR-1:0] mask,
                       output int first_low, output int first_high);
        first_low  = -1;
        first_high = -1;
        rail_ok = ~mask;
        for (int n = 1; n <= 40; n++) begin
            @(negedge clk);
            if (!rst_out_n && first_low < 0) first_low = n;
            if (rst_out_n && first_low >= 0 && first_high < 0) first_high = n;
            if (n == len) rail_ok = '1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        int n, fl, fh, exp_low;
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 rst_out_n in reset", rst_out_n, 0);
        check("R1 fault_out in reset", fault_out, 0);
        check("R1 en_drop_req in reset", en_drop_req, 0);
        check("R1 fault_chan in reset", fault_chan, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rst_out_n after reset", rst_out_n, 0);

        // R2 hold without sequencing done
        repeat (30) @(negedge clk);
        check("R2 low without seq_done", rst_out_n, 0);
        // R6 hold while one rail failed
        rail_ok = 4'b1110;
        seq_done = 1'b1;
        repeat (20) @(negedge clk);
        check("R6 low with failed rail", rst_out_n, 0);
        go_hold();

        // R2 sweep every delay, R10 shutdown after each
        for (int d = 0; d < 16; d++) begin
            bring_up(d, n);
            check("R2 release cycles", n, d + 2);
            shutdown = 1'b1;
            @(negedge clk);
            check("R10 shutdown drops reset", rst_out_n, 0);
            rail_ok = 4'b0000;
            repeat (8) @(negedge clk);
            check("R10 held low during shutdown", rst_out_n, 0);
            go_hold();
        end

        // R3 delay change mid-count ignored
        delay_cfg = 6'd10;
        seq_done = 1'b1;
        n = 0;
        while (!rst_out_n && n < 200) begin
            @(negedge clk);
            n++;
            if (n == 3) delay_cfg = 6'd1;
        end
        check("R3 mid-count delay change", n, 12);

        // R4 R5 R6 R11 dip sweep, escalation off, delay 5
        for (int len = 1; len <= 6; len++) begin
            go_hold();
            bring_up(5, n);
            dip(len, NR'(1) << (len % NR), fl, fh);
            exp_low = (len >= FS) ? FS + 1 : -1;
            if (len < FS) check("R4 short glitch ignored", fl, exp_low);
            else begin
                check("R5 qualified dip timing", fl, exp_low);
                check("R6 restart after recovery", fh, len + 3 + 5);
            end
            check("R11 no fault without option", fault_out, 0);
        end

        // R6 two rails down, one recovers
        go_hold();
        bring_up(3, n);
        rail_ok = 4'b1100;
        repeat (10) @(negedge clk);
        rail_ok = 4'b1101;
        repeat (10) @(negedge clk);
        check("R6 still low with one rail failed", rst_out_n, 0);
        rail_ok = 4'b1111;
        n = 0;
        while (!rst_out_n && n < 200) begin
            @(negedge clk);
            n++;
        end
        check("R6 release after last rail", n, 3 + 3);

        // R7 R8 escalation over every failure mask
        fault_on_uv = 1'b1;
        for (int m = 1; m < 16; m++) begin
            int low_idx;
            low_idx = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) low_idx = b;
            go_hold();
            bring_up(2, n);
            rail_ok = ~NR'(m);
            repeat (FS + 1) @(negedge clk);
            check("R7 fault_out raised", fault_out, 1);
            check("R7 en_drop_req raised", en_drop_req, 1);
            check("R7 reset low in fault", rst_out_n, 0);
            check("R8 lowest rail recorded", fault_chan, low_idx);
            rail_ok = '1;
            repeat (10) @(negedge clk);
            rail_ok = 4'b0111;
            repeat (FS + 3) @(negedge clk);
            rail_ok = '1;
            repeat (5) @(negedge clk);
            check("R7 fault held", fault_out, 1);
            check("R8 channel held", fault_chan, low_idx);
            if (m == 5) begin
                rst_dis = 1'b1;
                #1;
                check("R9 override in fault", rst_out_n, 1);
                rst_dis = 1'b0;
                #1;
                check("R9 override removed", rst_out_n, 0);
            end
            fault_clr = 1'b1;
            @(negedge clk);
            fault_clr = 1'b0;
            check("R8 clear drops fault", fault_out, 0);
            check("R8 clear zeroes channel", fault_chan, 0);
        end
        fault_on_uv = 1'b0;

        // R9 override in HOLD with failed rails
        go_hold();
        rail_ok = 4'b0000;
        repeat (FS + 2) @(negedge clk);
        rst_dis = 1'b1;
        #1;
        check("R9 override in hold", rst_out_n, 1);
        rst_dis = 1'b0;
        #1;
        check("R9 override released", rst_out_n, 0);

        finish_run();
    end

endmodule